// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Controller

This block collects up to 256 level-sensitive interrupt sources, packed 32 to a word, and presents them to several processors at once. The source levels form one shared status image. Each processor owns a private bank holding a mask word for every status word, and each bank drives its own interrupt line. A line is high while at least one source is high and not masked in that processor's bank, so software can steer a source to one processor by leaving it enabled only in that bank.

Software reaches the banks over a simple 32-bit register bus. A bank select input picks the processor's bank, and a word address picks one register inside it. The register space of a bank is four equal groups of `NUM_WORDS` words: raw status, current mask, a write-one-to-set mask port and a write-one-to-clear mask port. The groups move when the word count changes, so decoding always divides the address by the word count. Reads return data one cycle after the request, together with a valid strobe.

Top module: `banked_level_intc`

## Requirements
- R1: After reset every mask bit of every bank is 1 (all sources disabled), every `cpu_irq` bit is 0, and `bus_rvalid` is 0.
- R2: Source n lives in status word n/32 at bit n%32. Within a bank, word address a decodes as group a/NUM_WORDS and word a%NUM_WORDS, with group 0 = raw status, 1 = mask status, 2 = mask set, 3 = mask clear.
- R3: A status read returns the source levels at the read cycle regardless of any mask; a source that drops reads 0 again (nothing is latched).
- R4: A write to a mask-set word sets every mask bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R5: A write to a mask-clear word clears every mask bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R6: A write reaches only the bank named by `bus_cpu`; the masks of every other bank keep their values.
- R7: `cpu_irq[c]` is a register holding the OR over all words of status AND NOT mask of bank c, so it follows a source change after one clock edge and a mask write after two.
- R8: Reads of the mask-set and mask-clear groups return 0, and writes to the status and mask-status groups change nothing.
- R9: Every read request (`bus_en` high, `bus_we` low) raises `bus_rvalid` for exactly the next cycle with the data in `bus_rdata`; no other cycle raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_WORDS*32 | Level of each interrupt source |
| bus_en | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Bank (processor) selected by the access |
| bus_addr | input | ADDR_W | Word address inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| cpu_irq | output | NUM_CPUS | Interrupt line of each bank |

## Verification
The two functions that can meet in one cycle are a mask write and a change of the source levels that the same mask covers. The bench raises a source in the very cycle that a mask-clear write for it is issued on one bank, then judges the line at both following edges: the first edge must still see the old mask and leave the line low, the second must raise it. The other bank's line for the same source must stay low throughout.

// File: rtl/banked_level_intc.sv
module banked_level_intc #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  localparam int SRC_W  = NUM_WORDS * 32,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W = $clog2(4 * NUM_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_W-1:0]    src_level,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [CPU_W-1:0]    bus_cpu,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic [NUM_CPUS-1:0] cpu_irq
);

  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [1:0] GRP_STAT  = 2'd0;
  localparam logic [1:0] GRP_MSTAT = 2'd1;
  localparam logic [1:0] GRP_SET   = 2'd2;
  localparam logic [1:0] GRP_CLR   = 2'd3;

  logic [NUM_WORDS-1:0][31:0] src_w;
  logic [NUM_WORDS-1:0][31:0] mask_q [NUM_CPUS];
  logic                       irq_q  [NUM_CPUS];
  logic [1:0]                 grp;
  logic [WIDX_W-1:0]          widx;
  logic                       in_range;
  logic                       wr_req;
  logic                       rd_req;
  logic [31:0]                rd_next;

  assign src_w  = src_level;
  assign wr_req = bus_en && bus_we && in_range;
  assign rd_req = bus_en && !bus_we;

  always_comb begin
    in_range = int'(bus_addr) < 4 * NUM_WORDS;
    grp      = 2'(int'(bus_addr) / NUM_WORDS);
    widx     = WIDX_W'(int'(bus_addr) % NUM_WORDS);
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic [NUM_WORDS-1:0][31:0] live;
    logic                       hit;

    assign live = src_w & ~mask_q[c];
    assign hit  = wr_req && (int'(bus_cpu) == c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[c] <= '1;
      end else if (hit) begin
        if (grp == GRP_SET)
          mask_q[c][widx] <= mask_q[c][widx] | bus_wdata;
        else if (grp == GRP_CLR)
          mask_q[c][widx] <= mask_q[c][widx] & ~bus_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[c] <= 1'b0;
      else        irq_q[c] <= |live;
    end

    assign cpu_irq[c] = irq_q[c];

    // R6: a bank not addressed by a write keeps its mask
    assert_bank_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && bus_we && int'(bus_cpu) == c) |=> $stable(mask_q[c]));

    // R7: no source high means the line drops at the next edge
    assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_level == '0) |=> !cpu_irq[c]);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assert_set_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && int'(bus_cpu) == c && int'(bus_addr) == 2 * NUM_WORDS + w)
        |=> ((mask_q[c][w] & $past(bus_wdata)) == $past(bus_wdata)));

      assert_clear_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && int'(bus_cpu) == c && int'(bus_addr) == 3 * NUM_WORDS + w)
        |=> ((mask_q[c][w] & $past(bus_wdata)) == 32'd0));
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_range) begin
      case (grp)
        GRP_STAT:  rd_next = src_w[widx];
        GRP_MSTAT: begin
          for (int c = 0; c < NUM_CPUS; c++)
            if (int'(bus_cpu) == c) rd_next = mask_q[c][widx];
        end
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_next;
    end
  end

  // R8: mask-port reads return zero
  assert_port_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && int'(bus_addr) >= 2 * NUM_WORDS) |=> (bus_rdata == 32'd0));

  // R9: one strobe per read request
  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

endmodule

// File: tb/banked_level_intc_test.sv
`timescale 1ns/1ps
module banked_level_intc_test;
  localparam int NW = 2;
  localparam int NC = 2;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NW*32-1:0] src_level = '0;
  logic          bus_en = 0, bus_we = 0;
  logic [0:0]    bus_cpu = '0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NC-1:0] cpu_irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mdl [NC][NW];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  banked_level_intc #(.NUM_WORDS(NW), .NUM_CPUS(NC)) uut (
    .clk, .rst_n, .src_level, .bus_en, .bus_we, .bus_cpu, .bus_addr,
    .bus_wdata, .bus_rdata, .bus_rvalid, .cpu_irq);

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] irq_model();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((src_level[w*32 +: 32] & ~mdl[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  // driver: write, updating the model per R4/R5/R8
  task automatic bus_write(int cpu, int addr, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_cpu = 1'(cpu); bus_addr = 3'(addr); bus_wdata = d;
    if (addr / NW == 2) mdl[cpu][addr % NW] = mdl[cpu][addr % NW] | d;
    if (addr / NW == 3) mdl[cpu][addr % NW] = mdl[cpu][addr % NW] & ~d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  // driver: read, pushing the expected value into the scoreboard
  task automatic bus_read(int cpu, int addr, string tag);
    logic [31:0] e;
    case (addr / NW)
      0: e = src_level[(addr % NW)*32 +: 32];
      1: e = mdl[cpu][addr % NW];
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_en = 1; bus_we = 0; bus_cpu = 1'(cpu); bus_addr = 3'(addr);
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check(tag, 32'(cpu_irq), 32'(irq_model()));
  endtask

  // monitor: pops and compares as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) mdl[c][w] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq after reset", 32'(cpu_irq), 32'd0);
    check("R1 rvalid after reset", 32'(bus_rvalid), 32'd0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) bus_read(c, NW + w, "R1 R2 mask status after reset");

    // sources 3 and 37 high, all masked
    src_level[3] = 1; src_level[37] = 1;
    chk_irq("R7 all masked keeps lines low");
    bus_read(0, 0, "R2 R3 status word0");
    bus_read(1, 1, "R2 R3 status word1");

    // enable source 37 (word1 bit5) on cpu0 only
    bus_write(0, 3*NW + 1, 32'h0000_0020);
    chk_irq("R5 R7 cpu0 enabled src37");
    check("R6 cpu1 line unaffected", 32'(cpu_irq[1]), 32'd0);
    bus_read(1, NW + 1, "R6 cpu1 mask word1 untouched");
    bus_read(0, NW + 1, "R5 cpu0 mask word1");

    // drop source 37: level, not latched
    src_level[37] = 0;
    chk_irq("R7 line follows level drop");
    bus_read(0, 1, "R3 status not latched");

    // clear then partial set on cpu1 word0
    bus_write(1, 3*NW, 32'h0000_00F8);
    chk_irq("R5 R7 cpu1 src3 enabled");
    bus_write(1, 2*NW, 32'h0000_0018);
    chk_irq("R4 R7 cpu1 src3 masked again");
    bus_read(1, NW, "R4 set only ones");
    check("R6 cpu0 masks", 32'(cpu_irq[0]), 32'd0);

    // mask ports read zero; writes to status/mask status ignored
    bus_read(0, 2*NW, "R8 set port reads zero");
    bus_read(1, 3*NW + 1, "R8 clear port reads zero");
    bus_write(0, NW, 32'h0000_0000);
    bus_write(0, 0, 32'h0000_0000);
    bus_read(0, NW, "R8 mask status write ignored");
    chk_irq("R8 line unchanged after ignored writes");

    // same cycle: source 40 rises with a clear write for it on cpu1
    src_level[40] = 1;
    bus_en = 1; bus_we = 1; bus_cpu = 1'b1; bus_addr = 3'(3*NW + 1); bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    check("R7 first edge sees old mask", 32'(cpu_irq), 32'd0);
    mdl[1][1] = mdl[1][1] & ~32'h0000_0100;
    @(negedge clk);
    check("R7 second edge raises cpu1", 32'(cpu_irq), 32'b10);
    check("R6 same-cycle cpu0 stays low", 32'(cpu_irq[0]), 32'd0);

    // idle: no strobe
    @(negedge clk);
    check("R9 rvalid idle", 32'(bus_rvalid), 32'd0);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule